// File: doc/BRIEF.md
# Strap-Configured Management Bus Slave

This block is the register port through which an external management processor reads and writes 16-bit control words inside a switch device. The processor drives an active-low select, an active-low address strobe, a read/write line and an 11-bit word address. The port answers each access with an active-low ready and an active-low "16-bit port" acknowledge. Both are open-drain, so each is modelled as an enable that pulls the line low. The data bus is bidirectional. It is modelled as an input, an output and an output enable that is active only while read data is presented.

The bus flavour is fixed by five strap pins. They are captured while reset is held and frozen when it is released. The straps select:
- a 1X or 2X input clock; at 2X, every bus phase lasts two clocks;
- little- or big-endian byte order;
- the sense of the read/write line;
- normal ready, where ready comes with the read data, or early ready, where ready comes one phase ahead of the data.

One strap is a bus-width option that has no effect. Behind the port sit eight registers:
- register 0 is a control word whose bit 0 sets the interrupt polarity;
- register 1 is an interrupt status word; event inputs set its bits and writing 1 clears them;
- registers 2 to 7 are plain storage.

The single interrupt output reflects whether any status bit is set.

Flow control is done by ready alone. The processor holds select and strobe until it sees ready, and a new access is accepted only after select has been released. Bus signals carry no valid/ready stream.

Top module: `cpubus_slave`

## Requirements
- R1: The strap pins are copied into the configuration on every clock while `rst_n` is low. Once `rst_n` is high the configuration stays at the last value captured, and later changes on the strap pins have no effect.
- R2: Strap bit 0 low gives 1X clocking, where `rdy_oe` is high for exactly one clock per access. Strap bit 0 high gives 2X clocking, where each bus phase, including the ready phase, lasts exactly two clocks.
- R3: Strap bit 1 high selects big-endian order. In big-endian order, bus bits [15:8] map to register bits [7:0] and bus bits [7:0] map to register bits [15:8], on both writes and reads. Strap bit 1 low passes the bytes straight through.
- R4: With strap bit 2 low, `rwc` high means read and low means write. With strap bit 2 high, `rwc` high means write and low means read. The level is sampled when the access starts.
- R5: Strap bit 3 has no effect. `bs16_oe` is high from the first phase of an access until the phase after `cs_n` returns high, and is low otherwise.
- R6: Strap bit 4 high gives normal timing: on a read, `dat_oe` is high during the `rdy_oe` phase. Strap bit 4 low gives early timing: on a read, `dat_oe` is low during the `rdy_oe` phase and high in the phase that follows it.
- R7: An access starts only when `cs_n` and `ads_n` are both low at a phase edge. `cs_n` alone low, or `ads_n` alone low, produces no `rdy_oe` and no `bs16_oe`.
- R8: Each select produces exactly one access. The write data on `dat_in` is stored at the end of the `rdy_oe` phase. While `cs_n` stays low after that phase, `rdy_oe` is not asserted again.
- R9: Word addresses 0 to 7 hold 16-bit registers that read back what was last written. A read of any address from 8 upward returns 0, and a write to such an address changes no register.
- R10: A high bit on `evt_set` sets the matching bit of register 1 on the next clock. Writing 1 to a register-1 bit clears it. When a set and a clear of the same bit fall in the same clock, the set wins.
- R11: `irq` is the OR of the register-1 bits when register 0 bit 0 is 1. `irq` is the inverse of that OR when register 0 bit 0 is 0.
- R12: `dat_oe` is never high during a write access.
- R13: After reset, `rdy_oe`, `bs16_oe` and `dat_oe` are low, all registers are zero, and `irq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, 1X or 2X of the phase rate |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| strap_pins | input | 5 | Configuration straps, sampled during reset |
| cs_n | input | 1 | Active-low chip select |
| ads_n | input | 1 | Active-low address strobe |
| rwc | input | 1 | Read/write line, sense set by strap bit 2 |
| addr | input | 11 | Word address |
| dat_in | input | 16 | Write data from the bus |
| dat_out | output | 16 | Read data to the bus |
| dat_oe | output | 1 | Data bus output enable |
| rdy_oe | output | 1 | Pulls the ready line low when high |
| bs16_oe | output | 1 | Pulls the 16-bit acknowledge line low when high |
| evt_set | input | 16 | Per-bit set requests for the status register |
| irq | output | 1 | Interrupt request, polarity set by register 0 bit 0 |

## Verification
All sixteen combinations of clock ratio, byte order, read/write sense and ready timing are run. Each combination gets random reads, writes and event pulses over both mapped and unmapped addresses. A wrong byte order, a wrong read/write sense or a wrong ready timing shows up as a read-back or enable mismatch only in the strap settings it affects. The strap pins are randomised after reset on every access, which separates a latched configuration from a live one. Directed patterns also run: a partial select (select without strobe, and strobe without select), a hold of select after ready, and a write to the polarity bit through the swapped byte lane. These separate start decoding, one-access-per-select and lane mapping from the plain register path.

// File: rtl/cpubus_pkg.sv
package cpubus_pkg;
  localparam int DW        = 16;
  localparam int STRAP_W   = 5;
  localparam int CTRL_IDX  = 0;
  localparam int STAT_IDX  = 1;

  // bit positions follow strap pin order 4..0
  typedef struct packed {
    logic rdy_norm;
    logic width_opt;
    logic wr_high;
    logic big_end;
    logic clk_x2;
  } strap_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_LATE,
    ST_HOLD
  } bus_st_t;

  function automatic logic [DW-1:0] lane_swap(input logic [DW-1:0] v, input logic en);
    return en ? {v[DW/2-1:0], v[DW-1:DW/2]} : v;
  endfunction
endpackage

// File: rtl/cpubus_straps.sv
module cpubus_straps
  import cpubus_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] pins,
  output strap_t             cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= strap_t'(pins);
  end

  a_r1_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg));
endmodule

// File: rtl/cpubus_phase.sv
module cpubus_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic x2,
  output logic ph_en
);
  logic tog;

  always_ff @(posedge clk) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end

  assign ph_en = x2 ? tog : 1'b1;

  a_r2_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    !x2 |-> ph_en);
  a_r2_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (x2 && ph_en) |=> !ph_en);
endmodule

// File: rtl/cpubus_regfile.sv
module cpubus_regfile
  import cpubus_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] evt,
  output logic          irq
);
  localparam int IW = $clog2(NREG);

  logic [DW-1:0] regs [NREG];
  logic          wr_hit;
  logic          rd_hit;
  logic [IW-1:0] wr_idx;
  logic          any_stat;

  assign wr_hit = (wr_addr < AW'(NREG));
  assign rd_hit = (rd_addr < AW'(NREG));
  assign wr_idx = wr_addr[IW-1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic sel;
    assign sel = wr_en && wr_hit && (wr_idx == IW'(g));
    if (g == STAT_IDX) begin : g_stat
      always_ff @(posedge clk) begin
        if (!rst_n) regs[g] <= '0;
        else        regs[g] <= (regs[g] & ~(sel ? wr_data : '0)) | evt;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)   regs[g] <= '0;
        else if (sel) regs[g] <= wr_data;
      end
    end
  end

  assign rd_data  = rd_hit ? regs[rd_addr[IW-1:0]] : '0;
  assign any_stat = |regs[STAT_IDX];
  assign irq      = regs[CTRL_IDX][0] ? any_stat : ~any_stat;

  a_r10_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((regs[STAT_IDX] & $past(evt)) == $past(evt)));
  a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> $stable(regs[CTRL_IDX]));
endmodule

// File: rtl/cpubus_slave.sv
module cpubus_slave
  import cpubus_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_pins,
  input  logic               cs_n,
  input  logic               ads_n,
  input  logic               rwc,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      dat_in,
  output logic [DW-1:0]      dat_out,
  output logic               dat_oe,
  output logic               rdy_oe,
  output logic               bs16_oe,
  input  logic [DW-1:0]      evt_set,
  output logic               irq
);
  strap_t        cfg;
  logic          ph_en;
  bus_st_t       st;
  logic          rd_q;
  logic [AW-1:0] adr_q;
  logic          is_rd;
  logic          wr_en;
  logic [DW-1:0] reg_rd;

  cpubus_straps u_straps (
    .clk  (clk),
    .rst_n(rst_n),
    .pins (strap_pins),
    .cfg  (cfg)
  );

  cpubus_phase u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .x2   (cfg.clk_x2),
    .ph_en(ph_en)
  );

  assign is_rd = cfg.wr_high ? ~rwc : rwc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      rd_q  <= 1'b0;
      adr_q <= '0;
    end else if (ph_en) begin
      unique case (st)
        ST_IDLE: if (!cs_n && !ads_n) begin
          st    <= ST_XFER;
          rd_q  <= is_rd;
          adr_q <= addr;
        end
        ST_XFER: st <= (rd_q && !cfg.rdy_norm) ? ST_LATE : ST_HOLD;
        ST_LATE: st <= ST_HOLD;
        ST_HOLD: if (cs_n) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign wr_en   = ph_en && (st == ST_XFER) && !rd_q;
  assign rdy_oe  = (st == ST_XFER);
  assign bs16_oe = (st != ST_IDLE);
  assign dat_oe  = rd_q && (((st == ST_XFER) && cfg.rdy_norm) || (st == ST_LATE));
  assign dat_out = dat_oe ? lane_swap(reg_rd, cfg.big_end) : '0;

  cpubus_regfile #(.NREG(NREG), .AW(AW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(adr_q),
    .wr_data(lane_swap(dat_in, cfg.big_end)),
    .rd_addr(adr_q),
    .rd_data(reg_rd),
    .evt    (evt_set),
    .irq    (irq)
  );

  a_r6_early_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_en && st == ST_XFER && rd_q && !cfg.rdy_norm) |=> (dat_oe && !rdy_oe));
  a_r8_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && !cs_n) |=> !rdy_oe);
  a_r7_start_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && (cs_n || ads_n)) |=> !bs16_oe);
endmodule

// File: tb/tb_cpubus_slave.sv
module tb_cpubus_slave;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  strap_pins;
  logic        cs_n, ads_n, rwc;
  logic [10:0] addr;
  logic [15:0] dat_in, dat_out, evt_set;
  logic        dat_oe, rdy_oe, bs16_oe, irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [15:0] mdl [8];
  bit c_x2, c_big, c_wrh, c_norm;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpubus_slave dut (
    .clk(clk), .rst_n(rst_n), .strap_pins(strap_pins), .cs_n(cs_n), .ads_n(ads_n),
    .rwc(rwc), .addr(addr), .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe),
    .rdy_oe(rdy_oe), .bs16_oe(bs16_oe), .evt_set(evt_set), .irq(irq)
  );

  function automatic logic [15:0] sw(input logic [15:0] v, input bit en);
    return en ? {v[7:0], v[15:8]} : v;
  endfunction

  function automatic logic exp_irq();
    return mdl[0][0] ? (|mdl[1]) : ~(|mdl[1]);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] s);
    rst_n = 1'b0; cs_n = 1'b1; ads_n = 1'b1; rwc = 1'b0;
    addr = '0; dat_in = '0; evt_set = '0; strap_pins = s;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    strap_pins = 5'($urandom);
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    @(negedge clk);
    chk("R13 rdy", {15'd0, rdy_oe}, 16'd0);
    chk("R13 bs16", {15'd0, bs16_oe}, 16'd0);
    chk("R13 doe", {15'd0, dat_oe}, 16'd0);
    chk("R13 irq", {15'd0, irq}, 16'd1);
  endtask

  // is_rd: 1 read, 0 write. returns captured read data
  task automatic bus_op(input bit is_rd, input logic [10:0] a, input logic [15:0] d,
                        output logic [15:0] v);
    int n, w;
    logic doe_at;
    bit hold_ok, doe_wr;
    v = '0;
    cs_n = 1'b0; ads_n = 1'b0; addr = a; dat_in = d;
    rwc = c_wrh ? ~is_rd : is_rd;
    strap_pins = 5'($urandom);
    n = 0; doe_wr = 0;
    do begin
      @(negedge clk); n++;
      if (dat_oe) doe_wr = 1;
    end while (!rdy_oe && n < 12);
    chk("R2 rdy seen", {15'd0, rdy_oe}, 16'd1);
    chk("R5 bs16 with rdy", {15'd0, bs16_oe}, 16'd1);
    doe_at = dat_oe; v = dat_out; w = 0;
    while (rdy_oe && w < 6) begin
      w++; @(negedge clk);
      if (dat_oe && !is_rd) doe_wr = 1;
    end
    chk("R2 rdy width", 16'(w), c_x2 ? 16'd2 : 16'd1);
    if (is_rd) begin
      if (c_norm) chk("R6 normal data with rdy", {15'd0, doe_at}, 16'd1);
      else begin
        chk("R6 early no data with rdy", {15'd0, doe_at}, 16'd0);
        chk("R6 early data after rdy", {15'd0, dat_oe}, 16'd1);
        v = dat_out;
      end
    end
    hold_ok = 1;
    repeat (4) begin
      @(negedge clk);
      if (rdy_oe || !bs16_oe) hold_ok = 0;
      if (dat_oe && !is_rd) doe_wr = 1;
    end
    chk("R8 one access per select", {15'd0, hold_ok}, 16'd1);
    if (!is_rd) chk("R12 no drive on write", {15'd0, doe_wr}, 16'd0);
    cs_n = 1'b1; ads_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 bs16 released", {15'd0, bs16_oe}, 16'd0);
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    logic [15:0] st, junk;
    bus_op(1'b0, a, d, junk);
    st = sw(d, c_big);
    if (a < 8) begin
      if (a == 1) mdl[1] = mdl[1] & ~st;
      else        mdl[a[2:0]] = st;
    end
    chk("R11 irq after write", {15'd0, irq}, {15'd0, exp_irq()});
  endtask

  task automatic rd(input logic [10:0] a);
    logic [15:0] v, e;
    bus_op(1'b1, a, 16'($urandom), v);
    e = (a < 8) ? sw(mdl[a[2:0]], c_big) : 16'd0;
    chk(a < 8 ? "R9 R3 R4 read back" : "R9 unmapped read zero", v, e);
  endtask

  task automatic pulse(input logic [15:0] e);
    evt_set = e;
    @(negedge clk);
    evt_set = '0;
    mdl[1] = mdl[1] | e;
    @(negedge clk);
    chk("R10 R11 irq after event", {15'd0, irq}, {15'd0, exp_irq()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int cf = 0; cf < 16; cf++) begin
      logic [15:0] pv;
      bit ok;
      c_x2 = cf[0]; c_big = cf[1]; c_wrh = cf[2]; c_norm = cf[3];
      do_reset({c_norm, 1'($urandom), c_wrh, c_big, c_x2});
      // R7 partial selects
      ok = 1;
      cs_n = 1'b0; ads_n = 1'b1;
      repeat (4) begin @(negedge clk); if (rdy_oe || bs16_oe) ok = 0; end
      cs_n = 1'b1; ads_n = 1'b0;
      repeat (4) begin @(negedge clk); if (rdy_oe || bs16_oe) ok = 0; end
      ads_n = 1'b1;
      chk("R7 partial select ignored", {15'd0, ok}, 16'd1);
      // R3 polarity bit through byte lanes, R10 set/clear, R11
      pv = c_big ? 16'h0100 : 16'h0001;
      wr(11'd0, pv);
      chk("R3 lane map to ctrl bit0", {15'd0, irq}, 16'd0);
      pulse(16'h0008);
      chk("R11 active high irq", {15'd0, irq}, 16'd1);
      wr(11'd1, c_big ? 16'h0800 : 16'h0008);
      chk("R10 write one clears", {15'd0, irq}, 16'd0);
      // R9 unmapped write ignored
      wr(11'd2, 16'hA55A);
      wr(11'd10, 16'h1234);
      rd(11'd2);
      rd(11'd8);
      // random mix
      for (int k = 0; k < 24; k++) begin
        int op;
        logic [10:0] a;
        op = int'($urandom % 3);
        a  = 11'($urandom % 12);
        if (op == 0)      wr(a, 16'($urandom));
        else if (op == 1) rd(a);
        else              pulse(16'($urandom));
      end
      for (int r = 0; r < 8; r++) rd(11'(r));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule